// File: doc/BRIEF.md
# CAN Controller Initialization and Bus Integration Control

This block owns the initialization state of a CAN protocol controller and the way the controller rejoins the bus. It keeps an initialization flag and a configuration-unlock flag, decides when writes to the controller's configuration registers may land, and holds the transmit line recessive whenever the protocol engine is not allowed on the bus.

The initialization flag can be raised by software, by the hardware reset, by an uncorrectable error reported from the message RAM, or by the bus-off condition. Once software drops the flag, the block does not hand the bus to the protocol engine at once. It first watches the sampled receive bits for a run of consecutive recessive bits (eleven by default) that marks an idle bus. Any dominant bit restarts that count, and any set source sends the block back to initialization. The bit timing logic and the error counters are outside this block. Raising initialization leaves them and all configuration contents alone.

Top module: `can_init_ctrl`

## Requirements
- R1: After reset the state is initializing (ctrl_state = 2'b00). At any clock edge where ram_uncorr_err or bus_off is high, or a control-register write has bit 0 = 1, the state is initializing in the next cycle. A set source wins over a simultaneous clear request.
- R2: line_tx is 1 (recessive) in the initializing and integrating states. In the active state it equals pe_tx_bit in the same cycle.
- R3: The control register sits at host address 0, with bit 0 = initialization flag and bit 1 = configuration-unlock flag. A write with bit 0 = 0 while initializing, and with no set source, moves to integrating (2'b01) with the idle count at zero.
- R4: cfg_wr_permit is high exactly when the state is initializing and the unlock flag is set. cfg_wr_accept is high in a cycle with host_wr_en high and a host address other than 0, and only while cfg_wr_permit is high. In every other case the configuration write is ignored.
- R5: The unlock flag resets to 0. It takes bit 1 of a control write only when the state is initializing at that edge. It is 0 whenever the state is not initializing.
- R6: In integrating, the state becomes active (2'b10) in the cycle after the eleventh consecutive strobe with rx_bit = 1. bus_active is high only in the active state.
- R7: A strobe with rx_bit = 0 resets the recessive count to zero. Cycles without bit_strobe do not advance the count.
- R8: A set source during integrating returns the state to initializing and clears the count, so a later clear needs a full fresh run of eleven recessive bits.
- R9: ctrl_state takes only the values 2'b00, 2'b01 and 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | ADDR_W | Host write address; 0 selects the control register |
| host_wr_data | input | DATA_W | Host write data |
| ram_uncorr_err | input | 1 | Uncorrectable error reported from the message RAM |
| bus_off | input | 1 | Bus-off condition from error management |
| rx_bit | input | 1 | Sampled receive bit (1 = recessive) |
| bit_strobe | input | 1 | One-cycle pulse per bit time |
| pe_tx_bit | input | 1 | Transmit bit from the protocol engine |
| line_tx | output | 1 | Transmit bit driven to the transceiver |
| bus_active | output | 1 | Protocol engine may take part in bus activity |
| cfg_wr_permit | output | 1 | Configuration registers are writable |
| cfg_wr_accept | output | 1 | Current configuration write is accepted |
| ctrl_state | output | 2 | 00 initializing, 01 integrating, 10 active |

## Verification
Directed runs cover three idle-detection patterns. In the first, ten recessive bits are followed by a dominant bit, which shows that the count restarts rather than stalls. In the second, strobes are spread between idle cycles, which shows that only strobes advance the count. In the third, a set source arrives partway through a run, which shows that the count is cleared rather than resumed. Further runs hold a set source during a software clear to confirm the priority, and write the unlock bit in each state to tell a protected write from an ignored one. A long seeded random phase then mixes control and configuration writes, error pulses, strobes and mostly-recessive receive bits. Every cycle is compared against a cycle model held in the bench.

// File: rtl/can_init_pkg.sv
package can_init_pkg;

   typedef enum logic [1:0] {
      ST_INIT   = 2'b00,
      ST_INTEG  = 2'b01,
      ST_ACTIVE = 2'b10
   } ctl_state_e;

endpackage

// File: rtl/can_init_decode.sv
module can_init_decode #(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 8,
   parameter int CTRL_ADDR = 0,
   parameter int INIT_BIT  = 0,
   parameter int CCE_BIT   = 1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ctrl_wr,
   output logic              ctrl_init_val,
   output logic              ctrl_cce_val,
   output logic              cfg_wr_req
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

   logic hit_ctrl;

   always_comb begin
      hit_ctrl      = (wr_addr == CTRL_A);
      ctrl_wr       = wr_en && hit_ctrl;
      cfg_wr_req    = wr_en && !hit_ctrl;
      ctrl_init_val = wr_data[INIT_BIT];
      ctrl_cce_val  = wr_data[CCE_BIT];
   end

endmodule

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
   parameter int IDLE_BITS = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic strobe,
   input  logic rx,
   output logic idle_done
);

   localparam int CNT_W = (IDLE_BITS < 2) ? 1 : $clog2(IDLE_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_BITS - 1);

   logic [CNT_W-1:0] cnt;

   assign idle_done = en && strobe && rx && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!en) begin
         cnt <= '0;
      end else if (strobe) begin
         if (!rx || idle_done) cnt <= '0;
         else                  cnt <= cnt + 1'b1;
      end
   end

   // R7: a dominant sampled bit restarts the run
   a_r7_dominant_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      (en && strobe && !rx) |=> (cnt == '0));

   // R7: without a strobe the count holds or is cleared, never advances
   a_r7_no_strobe_no_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !strobe) |=> (cnt == $past(cnt) || cnt == '0));

   // R8: outside integration the count is zero
   a_r8_disabled_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));

   a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/can_init_fsm.sv
module can_init_fsm
   import can_init_pkg::*;
#(
   parameter bit HW_SET_EDGE = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ram_err,
   input  logic       bus_off,
   input  logic       ctrl_wr,
   input  logic       ctrl_init_val,
   input  logic       ctrl_cce_val,
   input  logic       idle_done,
   output logic       set_any,
   output ctl_state_e state,
   output logic       cce
);

   logic       hw_set;
   logic       sw_set;
   logic       clr_req;
   ctl_state_e state_nx;

   generate
      if (HW_SET_EDGE) begin : g_edge_set
         logic ram_q, bo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ram_q <= 1'b0;
               bo_q  <= 1'b0;
            end else begin
               ram_q <= ram_err;
               bo_q  <= bus_off;
            end
         end
         assign hw_set = (ram_err && !ram_q) || (bus_off && !bo_q);
      end else begin : g_level_set
         assign hw_set = ram_err || bus_off;
      end
   endgenerate

   always_comb begin
      sw_set  = ctrl_wr && ctrl_init_val;
      clr_req = ctrl_wr && !ctrl_init_val;
      set_any = hw_set || sw_set;
      state_nx = state;
      if (set_any) begin
         state_nx = ST_INIT;
      end else begin
         unique case (state)
            ST_INIT:   if (clr_req)   state_nx = ST_INTEG;
            ST_INTEG:  if (idle_done) state_nx = ST_ACTIVE;
            ST_ACTIVE: state_nx = ST_ACTIVE;
            default:   state_nx = ST_INIT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_INIT;
         cce   <= 1'b0;
      end else begin
         state <= state_nx;
         if (state_nx != ST_INIT)                cce <= 1'b0;
         else if (state == ST_INIT && ctrl_wr)   cce <= ctrl_cce_val;
      end
   end

   // R1: any set source lands in initialization
   a_r1_set_to_init: assert property (@(posedge clk) disable iff (!rst_n)
      set_any |=> (state == ST_INIT));

   // R3: clearing the flag starts integration
   a_r3_clear_integrates: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INIT && clr_req && !set_any) |=> (state == ST_INTEG));

   // R5: unlock flag only lives inside initialization
   a_r5_cce_only_in_init: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_INIT) |-> !cce);

   // R6: active is entered only from integration on a completed idle run
   a_r6_active_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |->
         ($past(state) == ST_INTEG && $past(idle_done)));

   // R9: legal encodings only
   a_r9_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
      state != ctl_state_e'(2'b11));

endmodule

// File: rtl/can_init_ctrl.sv
module can_init_ctrl
   import can_init_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 8,
   parameter int CTRL_ADDR   = 0,
   parameter int INIT_BIT    = 0,
   parameter int CCE_BIT     = 1,
   parameter int IDLE_BITS   = 11,
   parameter bit HW_SET_EDGE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr_en,
   input  logic [ADDR_W-1:0] host_wr_addr,
   input  logic [DATA_W-1:0] host_wr_data,
   input  logic              ram_uncorr_err,
   input  logic              bus_off,
   input  logic              rx_bit,
   input  logic              bit_strobe,
   input  logic              pe_tx_bit,
   output logic              line_tx,
   output logic              bus_active,
   output logic              cfg_wr_permit,
   output logic              cfg_wr_accept,
   output logic [1:0]        ctrl_state
);

   generate
      if (IDLE_BITS < 1) begin : g_bad_idle
         initial $fatal(1, "IDLE_BITS must be at least 1");
      end
      if (INIT_BIT >= DATA_W || CCE_BIT >= DATA_W || INIT_BIT == CCE_BIT) begin : g_bad_bits
         initial $fatal(1, "control bit positions invalid");
      end
      if (CTRL_ADDR < 0 || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         initial $fatal(1, "CTRL_ADDR out of range");
      end
   endgenerate

   logic       ctrl_wr, ctrl_init_val, ctrl_cce_val, cfg_wr_req;
   logic       set_any, idle_done, cce, cnt_en;
   ctl_state_e state;

   can_init_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
      .INIT_BIT(INIT_BIT), .CCE_BIT(CCE_BIT)
   ) u_decode (
      .wr_en(host_wr_en), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
      .ctrl_wr(ctrl_wr), .ctrl_init_val(ctrl_init_val),
      .ctrl_cce_val(ctrl_cce_val), .cfg_wr_req(cfg_wr_req)
   );

   can_init_fsm #(.HW_SET_EDGE(HW_SET_EDGE)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .ram_err(ram_uncorr_err), .bus_off(bus_off),
      .ctrl_wr(ctrl_wr), .ctrl_init_val(ctrl_init_val),
      .ctrl_cce_val(ctrl_cce_val), .idle_done(idle_done),
      .set_any(set_any), .state(state), .cce(cce)
   );

   assign cnt_en = (state == ST_INTEG) && !set_any;

   can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
      .clk(clk), .rst_n(rst_n), .en(cnt_en),
      .strobe(bit_strobe), .rx(rx_bit), .idle_done(idle_done)
   );

   always_comb begin
      bus_active    = (state == ST_ACTIVE);
      line_tx       = bus_active ? pe_tx_bit : 1'b1;
      cfg_wr_permit = (state == ST_INIT) && cce;
      cfg_wr_accept = cfg_wr_req && cfg_wr_permit;
      ctrl_state    = state;
   end

   // R4: no configuration write slips through outside the protected window
   a_r4_accept_needs_permit: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_accept |-> (ctrl_state == 2'b00 && cfg_wr_permit));

   // R2: the protocol engine reaches the line only when active
   a_r2_quiet_unless_active: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_active |-> line_tx);

endmodule

// File: tb/can_init_ctrl_bench.sv
`timescale 1ns/1ps
module can_init_ctrl_bench;

   localparam int ADDR_W = 4;
   localparam int DATA_W = 8;
   localparam int IDLE   = 11;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              host_wr_en = 1'b0;
   logic [ADDR_W-1:0] host_wr_addr = '0;
   logic [DATA_W-1:0] host_wr_data = '0;
   logic              ram_uncorr_err = 1'b0;
   logic              bus_off = 1'b0;
   logic              rx_bit = 1'b1;
   logic              bit_strobe = 1'b0;
   logic              pe_tx_bit = 1'b0;
   logic              line_tx, bus_active, cfg_wr_permit, cfg_wr_accept;
   logic [1:0]        ctrl_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   can_init_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_can_init_ctrl (
      .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en),
      .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
      .ram_uncorr_err(ram_uncorr_err), .bus_off(bus_off),
      .rx_bit(rx_bit), .bit_strobe(bit_strobe), .pe_tx_bit(pe_tx_bit),
      .line_tx(line_tx), .bus_active(bus_active),
      .cfg_wr_permit(cfg_wr_permit), .cfg_wr_accept(cfg_wr_accept),
      .ctrl_state(ctrl_state)
   );

   // cycle model built from the requirements
   logic [1:0] m_state;
   logic       m_cce;
   int         m_cnt;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 2'b00; m_cce <= 1'b0; m_cnt <= 0;
      end else begin
         automatic bit cw  = host_wr_en && host_wr_addr == 0;
         automatic bit set = ram_uncorr_err || bus_off || (cw && host_wr_data[0]);
         if (set) begin
            if (m_state == 2'b00 && cw) m_cce <= host_wr_data[1];
            m_state <= 2'b00; m_cnt <= 0;
         end else if (m_state == 2'b00 && cw) begin
            m_state <= 2'b01; m_cnt <= 0; m_cce <= 1'b0;
         end else if (m_state == 2'b01 && bit_strobe) begin
            if (!rx_bit) m_cnt <= 0;
            else if (m_cnt == IDLE - 1) begin m_state <= 2'b10; m_cnt <= 0; end
            else m_cnt <= m_cnt + 1;
         end
      end
   end

   function automatic logic f_tx(logic [1:0] st, logic pe);
      return (st == 2'b10) ? pe : 1'b1;
   endfunction
   function automatic logic f_permit(logic [1:0] st, logic c);
      return (st == 2'b00) && c;
   endfunction
   function automatic logic f_accept(logic [1:0] st, logic c, logic we, logic [ADDR_W-1:0] a);
      return we && (a != 0) && f_permit(st, c);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk(ctrl_state == m_state, "R9 ctrl_state", ctrl_state, m_state);
      chk(bus_active == (m_state == 2'b10), "R6 bus_active", bus_active, m_state == 2'b10);
      chk(line_tx == f_tx(m_state, pe_tx_bit), "R2 line_tx", line_tx, f_tx(m_state, pe_tx_bit));
      chk(cfg_wr_permit == f_permit(m_state, m_cce), "R4 cfg_wr_permit",
          cfg_wr_permit, f_permit(m_state, m_cce));
      chk(cfg_wr_accept == f_accept(m_state, m_cce, host_wr_en, host_wr_addr),
          "R4 cfg_wr_accept", cfg_wr_accept,
          f_accept(m_state, m_cce, host_wr_en, host_wr_addr));
   endtask

   task automatic cyc();
      @(posedge clk); #2; compare();
   endtask

   task automatic wr_ctrl(input bit init_b, input bit cce_b);
      host_wr_en = 1'b1; host_wr_addr = '0;
      host_wr_data = {6'b0, cce_b, init_b};
      cyc();
      host_wr_en = 1'b0;
   endtask

   task automatic bits(input int n, input bit v);
      for (int i = 0; i < n; i++) begin
         bit_strobe = 1'b1; rx_bit = v; cyc();
         bit_strobe = 1'b0; rx_bit = 1'b1; cyc();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd715));
      repeat (3) @(posedge clk);
      #2;
      // R1 reset state
      chk(ctrl_state == 2'b00, "R1 reset state", ctrl_state, 0);
      chk(cfg_wr_permit == 1'b0, "R5 reset unlock", cfg_wr_permit, 0);
      chk(line_tx == 1'b1, "R2 reset recessive", line_tx, 1);
      rst_n = 1'b1;
      cyc();

      // R4/R5 unlock inside init, protected write accepted
      wr_ctrl(1'b1, 1'b1);
      chk(cfg_wr_permit == 1'b1, "R4 permit in init+unlock", cfg_wr_permit, 1);
      host_wr_en = 1'b1; host_wr_addr = 4'd3; host_wr_data = 8'hA5; #1;
      chk(cfg_wr_accept == 1'b1, "R4 write accepted", cfg_wr_accept, 1);
      cyc(); host_wr_en = 1'b0;

      // R3 clear -> integrating, R5 unlock auto-clears
      wr_ctrl(1'b0, 1'b1);
      chk(ctrl_state == 2'b01, "R3 integrating", ctrl_state, 1);
      chk(cfg_wr_permit == 1'b0, "R5 unlock cleared", cfg_wr_permit, 0);
      host_wr_en = 1'b1; host_wr_addr = 4'd5; #1;
      chk(cfg_wr_accept == 1'b0, "R4 write ignored", cfg_wr_accept, 0);
      cyc(); host_wr_en = 1'b0;
      wr_ctrl(1'b0, 1'b1);
      chk(cfg_wr_permit == 1'b0, "R5 unlock write ignored outside init", cfg_wr_permit, 0);

      // R7 dominant restart, gaps do not advance
      bits(10, 1'b1);
      bits(1, 1'b0);
      chk(ctrl_state == 2'b01, "R7 dominant restarts", ctrl_state, 1);
      repeat (5) cyc();
      bits(10, 1'b1);
      chk(ctrl_state == 2'b01, "R7 ten bits not enough", ctrl_state, 1);
      bit_strobe = 1'b1; rx_bit = 1'b1; cyc();
      chk(ctrl_state == 2'b10, "R6 active after eleventh", ctrl_state, 2);
      bit_strobe = 1'b0;
      for (int i = 0; i < 6; i++) begin
         pe_tx_bit = i[0]; #1;
         chk(line_tx == pe_tx_bit, "R2 line follows engine", line_tx, pe_tx_bit);
         cyc();
      end

      // R1 RAM error
      ram_uncorr_err = 1'b1; cyc(); ram_uncorr_err = 1'b0;
      chk(ctrl_state == 2'b00 && line_tx, "R1 ram error to init", ctrl_state, 0);

      // R8 set source while integrating
      wr_ctrl(1'b0, 1'b0);
      bits(6, 1'b1);
      bus_off = 1'b1; cyc(); bus_off = 1'b0;
      chk(ctrl_state == 2'b00, "R8 bus-off during integration", ctrl_state, 0);
      wr_ctrl(1'b0, 1'b0);
      bits(10, 1'b1);
      chk(ctrl_state == 2'b01, "R8 count restarted", ctrl_state, 1);
      bits(1, 1'b1);
      chk(ctrl_state == 2'b10, "R8 full run reaches active", ctrl_state, 2);

      // R1 set wins over clear
      bus_off = 1'b1; cyc();
      wr_ctrl(1'b0, 1'b0);
      chk(ctrl_state == 2'b00, "R1 set beats clear", ctrl_state, 0);
      bus_off = 1'b0; cyc();

      // R5 unlock write while active is ignored
      wr_ctrl(1'b0, 1'b0); bits(11, 1'b1);
      wr_ctrl(1'b1, 1'b1);
      chk(ctrl_state == 2'b00 && !cfg_wr_permit, "R5 unlock from active ignored",
          cfg_wr_permit, 0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         host_wr_en     = ($urandom % 16) == 0;
         host_wr_addr   = ADDR_W'($urandom % 3);
         host_wr_data   = DATA_W'($urandom);
         if (host_wr_addr == 0 && host_wr_data[0] && ($urandom % 2)) host_wr_data[0] = 1'b0;
         ram_uncorr_err = ($urandom % 300) == 0;
         bus_off        = ($urandom % 300) == 0;
         bit_strobe     = ($urandom % 3) == 0;
         rx_bit         = ($urandom % 10) != 0;
         pe_tx_bit      = 1'($urandom);
         cyc();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule